// File: doc/BRIEF.md
# FSK Message End Detector

This block decides when a frequency-shift-keyed data message on a telephone line has finished, so that a line controller can hand the voice path back to the user in time. Carrier loss alone is a weak indication on a noisy line. The block therefore declares the end of a message on whichever of three independent conditions is met first:

- the carrier goes away;
- too many characters arrive with a bad stop bit;
- the demodulated line level stays at mark, or stays at space, for too long.

A new carrier arms the detector for a new message. The result is a sticky end flag and a 2-bit code that records which condition fired.

The inputs are plain control pins with no stream data path, so nothing at the edge of the block uses a handshake:

- `carrier_n` is active low: 0 means a carrier is present.
- `frame_err` is a one-cycle strobe for each character whose trailing stop bit was sampled as 0 instead of 1.
- `bit_lvl` is the demodulated level. It is sampled only on cycles where `tick_ms` pulses, and `tick_ms` pulses once per millisecond.

Detection takes a few clock cycles at most, which is far inside the 50 ms budget for restoring the voice path.

Top module: `fsk_msg_end_detect`

## Requirements
- R1: After reset, `eom` is 0, `eom_cause` is 0, and the detector is disarmed, so no condition can set `eom` until a carrier start occurs.
- R2: A carrier start is a 1-to-0 transition of `carrier_n` between consecutive clocks. It arms the detector and clears `eom`, `eom_cause`, the framing-error count and the run timer. On the clock after the start, `eom` reads 0.
- R3: While the detector is armed, `carrier_n` = 1 sets `eom` with `eom_cause` = 0 (carrier loss) within 2 clock cycles.
- R4: While the detector is armed, the sixth `frame_err` strobe sets `eom` with `eom_cause` = 1. Five strobes leave `eom` at 0. The error count saturates instead of wrapping, so any longer burst also ends with `eom_cause` = 1.
- R5: While the detector is armed, the run timer adds 1 on each `tick_ms` whose sampled `bit_lvl` equals the level previously held. At a carrier start, the held level is loaded from `bit_lvl`. After 151 such ticks, `eom` is set with `eom_cause` = 2. After 150 such ticks, `eom` is still 0.
- R6: A `tick_ms` that samples a `bit_lvl` different from the held level resets the run timer to 0 and makes that sample the new held level.
- R7: When conditions fire together, carrier loss (code 0) wins over framing errors (code 1), and framing errors win over run length (code 2).
- R8: Once set, `eom` and `eom_cause` hold their values through any later carrier loss, framing errors or ticks, until `clr` or a carrier start.
- R9: `clr` sets `eom` and `eom_cause` to 0 and leaves the detector disarmed. Carrier absence, framing errors and ticks then have no effect on `eom` until the next carrier start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse once per millisecond |
| carrier_n | input | 1 | Carrier detect, 0 = carrier present |
| frame_err | input | 1 | One-cycle strobe for each character with a bad stop bit |
| bit_lvl | input | 1 | Demodulated line level, 1 = mark |
| clr | input | 1 | Clears the end flag and the cause code |
| eom | output | 1 | End-of-message flag, sticky |
| eom_cause | output | 2 | First condition that fired: 0 carrier, 1 framing, 2 run length |

## Verification
If the framing-error count, the run timer or the held level is wrong, the flag rises early or late. A sweep over the exact number of strobes and ticks around each limit exposes this as a flag that is set one event too soon or one event too late. If the arm bit or the priority logic is wrong, the cause code is wrong, or the flag reacts while the detector is disarmed. Both show on the ports within two clock cycles of the stimulus that triggers them.

// File: rtl/fsk_eom_pkg.sv
package fsk_eom_pkg;
  typedef enum logic [1:0] {
    CAUSE_CARRIER = 2'd0,
    CAUSE_FRAMING = 2'd1,
    CAUSE_RUN     = 2'd2
  } eom_cause_e;
endpackage

// File: rtl/fsk_fe_counter.sv
module fsk_fe_counter #(
  parameter int FE_LIMIT = 5,
  localparam int FE_W = $clog2(FE_LIMIT + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  input  logic fe_strobe,
  output logic fire
);
  localparam logic [FE_W-1:0] CNT_MAX = '1;
  logic [FE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clear) cnt <= '0;
    else if (en && fe_strobe && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign fire = (int'(cnt) > FE_LIMIT);

  // R4: counter saturates instead of wrapping
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && fe_strobe && !clear) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/fsk_run_timer.sv
module fsk_run_timer #(
  parameter int RUN_LIMIT = 150,
  localparam int RUN_W = $clog2(RUN_LIMIT + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  input  logic tick,
  input  logic lvl,
  output logic fire
);
  localparam logic [RUN_W-1:0] CNT_MAX = '1;
  logic [RUN_W-1:0] cnt;
  logic held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      held <= 1'b1;
    end else if (clear) begin
      cnt  <= '0;
      held <= lvl;
    end else if (en && tick) begin
      if (lvl != held) begin
        cnt  <= '0;
        held <= lvl;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign fire = (int'(cnt) > RUN_LIMIT);

  // R6: a sampled level change restarts the run
  a_r6_change_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && lvl != held && !clear) |=> (cnt == '0));
endmodule

// File: rtl/fsk_eom_ctrl.sv
module fsk_eom_ctrl
  import fsk_eom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       carrier_n,
  input  logic       clr,
  input  logic       fe_fire,
  input  logic       run_fire,
  output logic       start,
  output logic       armed,
  output logic       eom,
  output logic [1:0] cause
);
  logic carrier_q;
  logic loss;
  eom_cause_e pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carrier_q <= 1'b1;
    else carrier_q <= carrier_n;
  end

  assign start = carrier_q && !carrier_n;
  assign loss  = carrier_n;

  always_comb begin
    if (loss) pick = CAUSE_CARRIER;
    else if (fe_fire) pick = CAUSE_FRAMING;
    else pick = CAUSE_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      eom   <= 1'b0;
      cause <= 2'd0;
    end else if (start) begin
      armed <= 1'b1;
      eom   <= 1'b0;
      cause <= 2'd0;
    end else if (armed && (loss || fe_fire || run_fire)) begin
      armed <= 1'b0;
      eom   <= 1'b1;
      cause <= pick;
    end else if (clr) begin
      eom   <= 1'b0;
      cause <= 2'd0;
    end
  end

  // R3: carrier loss while armed raises the flag with code 0
  a_r3_loss_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && carrier_n) |=> (eom && cause == 2'd0));
  // R2: a carrier start arms and clears the flag
  a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (armed && !eom));
  // R8: a set flag and its cause hold until clr or a new start
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (eom && !clr && !start) |=> (eom && $stable(cause)));
  // R9: the flag never rises while disarmed
  a_r9_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !eom && !start) |=> !eom);
endmodule

// File: rtl/fsk_msg_end_detect.sv
module fsk_msg_end_detect #(
  parameter int FE_LIMIT  = 5,
  parameter int RUN_LIMIT = 150
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       carrier_n,
  input  logic       frame_err,
  input  logic       bit_lvl,
  input  logic       clr,
  output logic       eom,
  output logic [1:0] eom_cause
);
  logic start, armed, fe_fire, run_fire;

  fsk_eom_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .carrier_n(carrier_n), .clr(clr),
    .fe_fire(fe_fire), .run_fire(run_fire), .start(start), .armed(armed),
    .eom(eom), .cause(eom_cause)
  );

  fsk_fe_counter #(.FE_LIMIT(FE_LIMIT)) u_fe (
    .clk(clk), .rst_n(rst_n), .clear(start), .en(armed),
    .fe_strobe(frame_err), .fire(fe_fire)
  );

  fsk_run_timer #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk(clk), .rst_n(rst_n), .clear(start), .en(armed),
    .tick(tick_ms), .lvl(bit_lvl), .fire(run_fire)
  );
endmodule

// File: tb/test_fsk_msg_end_detect.sv
module test_fsk_msg_end_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, carrier_n = 1'b1, frame_err = 1'b0, bit_lvl = 1'b1, clr = 1'b0;
  logic eom;
  logic [1:0] eom_cause;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fsk_msg_end_detect i_fsk_msg_end_detect (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .carrier_n(carrier_n),
    .frame_err(frame_err), .bit_lvl(bit_lvl), .clr(clr),
    .eom(eom), .eom_cause(eom_cause)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic arm();
    carrier_n = 1'b1; idle(3);
    carrier_n = 1'b0; idle(2);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1; idle(1);
      tick_ms = 1'b0; idle(1);
    end
  endtask

  task automatic errs(int n);
    for (int i = 0; i < n; i++) begin
      frame_err = 1'b1; idle(1);
      frame_err = 1'b0; idle(1);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(2);
    chk("R1 eom after reset", eom, 0);
    chk("R1 cause after reset", eom_cause, 0);
    errs(8); ticks(160); idle(3);
    chk("R1 disarmed ignores events", eom, 0);

    // R3 carrier loss
    arm();
    chk("R2 armed flag clear", eom, 0);
    carrier_n = 1'b1; idle(2);
    chk("R3 loss flag", eom, 1);
    chk("R3 loss cause", eom_cause, 0);
    carrier_n = 1'b0; idle(1);
    chk("R2 start clears flag", eom, 0);
    chk("R2 start clears cause", eom_cause, 0);

    // R4 sweep of framing-error counts
    for (int n = 0; n <= 20; n++) begin
      arm(); errs(n); idle(3);
      chk("R4 flag vs error count", eom, (n > 5) ? 1 : 0);
      if (n > 5) chk("R4 cause", eom_cause, 1);
    end

    // R5 sweep around the run limit, both levels
    for (int lv = 0; lv < 2; lv++) begin
      for (int n = 148; n <= 153; n++) begin
        bit_lvl = lv[0]; arm(); ticks(n); idle(3);
        chk("R5 flag vs run length", eom, (n > 150) ? 1 : 0);
        if (n > 150) chk("R5 cause", eom_cause, 2);
      end
    end

    // R6 level change restarts
    bit_lvl = 1'b1; arm(); ticks(140);
    bit_lvl = 1'b0; ticks(140);
    bit_lvl = 1'b1; ticks(150); idle(3);
    chk("R6 restart no flag", eom, 0);
    ticks(2); idle(3);
    chk("R6 flag after full run", eom, 1);
    chk("R6 cause", eom_cause, 2);

    // R7 carrier beats framing on the same cycle
    arm(); errs(5);
    frame_err = 1'b1; carrier_n = 1'b1; idle(1);
    frame_err = 1'b0; idle(3);
    chk("R7 carrier over framing", eom_cause, 0);
    // R7 framing beats run on the same cycle
    carrier_n = 1'b0; idle(2); bit_lvl = 1'b1;
    errs(5); ticks(150);
    tick_ms = 1'b1; frame_err = 1'b1; idle(1);
    tick_ms = 1'b0; frame_err = 1'b0; idle(3);
    chk("R7 framing over run flag", eom, 1);
    chk("R7 framing over run cause", eom_cause, 1);

    // R8 sticky
    errs(4); ticks(200); carrier_n = 1'b1; idle(4);
    chk("R8 flag held", eom, 1);
    chk("R8 cause held", eom_cause, 1);

    // R9 clear then disarmed
    clr = 1'b1; idle(1); clr = 1'b0; idle(1);
    chk("R9 clr flag", eom, 0);
    chk("R9 clr cause", eom_cause, 0);
    errs(10); ticks(160); idle(3);
    chk("R9 disarmed flag", eom, 0);
    carrier_n = 1'b0; idle(2);
    carrier_n = 1'b1; idle(2);
    chk("R9 rearmed loss", eom, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule